// File: doc/BRIEF.md
# Tag-Matching Operand Station Cluster

This block sits in front of a single pipelined execution unit and holds a small pool of waiting operations. An in-order front end hands it one operation per cycle. Each source operand arrives either as a finished value or as the tag of the station that will eventually produce it. Stations that still lack an operand watch two broadcast result buses: one shared external bus that carries results from other clusters, and the cluster's own output bus. A station captures a value when the tag on a bus matches the tag it is waiting for.

A station that holds both operand values becomes eligible for execution, whatever its age. One eligible station per cycle is sent down the execution pipeline. When the operation completes, the result is broadcast with that station's own tag, which serves as the renamed destination register. The station then becomes free again. Register numbers never enter the block: a dependent operation refers only to the tag of the station that produces its input.

Top module: `rs_cluster`

## Requirements
- R1: When a dispatch handshake completes (disp_valid and disp_ready high at a clock edge), the operation goes to the lowest-indexed free station. Station i carries the tag BASE_TAG+i. disp_ready is high exactly when at least one station is free. After reset all stations are free, and iss_valid and res_valid are low.
- R2: Opcode encoding is 0 add, 1 subtract (a minus b), 2 bitwise and, 3 bitwise xor, all modulo 2^DATA_W. A result appears on res_valid/res_tag/res_data EXE_LAT cycles after its station is shown on the issue port.
- R3: A source dispatched with a nonzero tag waits. It captures bus_in_data in the cycle that bus_in_valid is high with a matching bus_in_tag. Every station waiting on that tag captures the value in the same cycle.
- R4: Waiting sources also capture from the cluster's own result output. This lets dependent operations chain inside the cluster.
- R5: At most one station is issued per cycle. Among the eligible stations, the lowest-indexed one is chosen.
- R6: A station holding both values may issue ahead of older stations that are still waiting. It stays eligible until it is issued.
- R7: Each result is broadcast with the tag of the station that held the operation.
- R8: While every station is busy, disp_ready is low and a dispatch attempt changes no state. No extra operation is issued or completed because of it.
- R9: A station stays busy through the cycle in which its result is broadcast. It becomes free for dispatch in the following cycle.
- R10: A dispatched source whose tag matches a bus broadcast in that same cycle takes the bus value directly and does not wait.
- R11: A broadcast whose tag matches no waiting source has no effect on any station.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | A station is free |
| disp_op | input | 2 | Operation code |
| disp_tag_a | input | TAG_W | Producer tag of source a, 0 when the value is present |
| disp_val_a | input | DATA_W | Value of source a |
| disp_tag_b | input | TAG_W | Producer tag of source b, 0 when the value is present |
| disp_val_b | input | DATA_W | Value of source b |
| bus_in_valid | input | 1 | External broadcast valid |
| bus_in_tag | input | TAG_W | External broadcast tag |
| bus_in_data | input | DATA_W | External broadcast value |
| iss_valid | output | 1 | A station is sent to the execution unit this cycle |
| iss_tag | output | TAG_W | Tag of the issued station |
| iss_op | output | 2 | Operation of the issued station |
| iss_a | output | DATA_W | Operand a sent to the unit |
| iss_b | output | DATA_W | Operand b sent to the unit |
| res_valid | output | 1 | Result broadcast valid |
| res_tag | output | TAG_W | Tag of the station that produced the result |
| res_data | output | DATA_W | Result value |

## Verification
The bench sweeps every opcode over edge operand values and compares results in order. It then targets the cases where tag matching is easy to get wrong. A design that compared the wrong tag, or captured any broadcast, would issue a station early on an unrelated tag. A design without the dispatch-cycle bypass would leave an operand waiting forever for a broadcast that has already passed. A design that ignored its own output bus would stall dependent chains. A design with a wrong priority, freeing rule or full-cluster guard would issue stations in a different order, reopen dispatch one cycle early or late, or produce an extra result from a dispatch that should have been refused.

// File: rtl/rs_pkg.sv
package rs_pkg;
   typedef enum logic [1:0] {
      OP_ADD = 2'd0,
      OP_SUB = 2'd1,
      OP_AND = 2'd2,
      OP_XOR = 2'd3
   } rs_op_e;

   localparam int NUM_BUS = 2;   // external bus, own output bus
   localparam int NUM_SRC = 2;
endpackage

// File: rtl/rs_prio_pick.sv
module rs_prio_pick #(
   parameter int N = 4
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] gnt_o,
   output logic         any_o
);
   if (N < 1) begin : g_bad_n
      $error("rs_prio_pick: N must be at least 1");
   end

   // isolate the lowest set bit
   assign gnt_o = req_i & (~req_i + N'(1));
   assign any_o = |req_i;
endmodule

// File: rtl/rs_entry.sv
module rs_entry
   import rs_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int TAG_W  = 3
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 alloc_i,
   input  rs_op_e                               op_i,
   input  logic [NUM_SRC-1:0][TAG_W-1:0]        tag_i,
   input  logic [NUM_SRC-1:0][DATA_W-1:0]       val_i,
   input  logic [NUM_BUS-1:0]                   bus_v_i,
   input  logic [NUM_BUS-1:0][TAG_W-1:0]        bus_t_i,
   input  logic [NUM_BUS-1:0][DATA_W-1:0]       bus_d_i,
   input  logic                                 grant_i,
   input  logic                                 free_i,
   output logic                                 busy_o,
   output logic                                 ready_o,
   output rs_op_e                               op_o,
   output logic [NUM_SRC-1:0][DATA_W-1:0]       opnd_o
);
   logic                                busy_q, fired_q;
   rs_op_e                              op_q;
   logic [NUM_SRC-1:0]                  have_q;
   logic [NUM_SRC-1:0][TAG_W-1:0]       wait_q;
   logic [NUM_SRC-1:0][DATA_W-1:0]      val_q;

   logic [NUM_SRC-1:0]                  in_hit, sn_hit;
   logic [NUM_SRC-1:0][DATA_W-1:0]      in_val, sn_val;

   always_comb begin
      for (int s = 0; s < NUM_SRC; s++) begin
         in_hit[s] = (tag_i[s] == '0);
         in_val[s] = val_i[s];
         sn_hit[s] = 1'b0;
         sn_val[s] = val_q[s];
         for (int b = 0; b < NUM_BUS; b++) begin
            if (tag_i[s] != '0 && bus_v_i[b] && bus_t_i[b] == tag_i[s]) begin
               in_hit[s] = 1'b1;
               in_val[s] = bus_d_i[b];
            end
            if (bus_v_i[b] && bus_t_i[b] == wait_q[s]) begin
               sn_hit[s] = 1'b1;
               sn_val[s] = bus_d_i[b];
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         fired_q <= 1'b0;
         op_q    <= OP_ADD;
         have_q  <= '0;
         wait_q  <= '0;
         val_q   <= '0;
      end else if (alloc_i) begin
         busy_q  <= 1'b1;
         fired_q <= 1'b0;
         op_q    <= op_i;
         have_q  <= in_hit;
         wait_q  <= tag_i;
         val_q   <= in_val;
      end else begin
         if (free_i)  busy_q  <= 1'b0;
         if (grant_i) fired_q <= 1'b1;
         for (int s = 0; s < NUM_SRC; s++) begin
            if (busy_q && !have_q[s] && sn_hit[s]) begin
               have_q[s] <= 1'b1;
               val_q[s]  <= sn_val[s];
            end
         end
      end
   end

   assign busy_o  = busy_q;
   assign ready_o = busy_q && !fired_q && (&have_q);
   assign op_o    = op_q;
   assign opnd_o  = val_q;

   AST_GRANT_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
      grant_i |-> ready_o);  // R5
   AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && !grant_i) |=> ready_o);  // R6
   AST_FREE_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      free_i |-> (busy_q && fired_q));  // R9
   AST_NO_ALLOC_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_i |-> !busy_q);  // R8
endmodule

// File: rtl/rs_exec_pipe.sv
module rs_exec_pipe
   import rs_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int TAG_W  = 3,
   parameter int LAT    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid_i,
   input  rs_op_e            in_op_i,
   input  logic [DATA_W-1:0] in_a_i,
   input  logic [DATA_W-1:0] in_b_i,
   input  logic [TAG_W-1:0]  in_tag_i,
   output logic              out_valid_o,
   output logic [TAG_W-1:0]  out_tag_o,
   output logic [DATA_W-1:0] out_data_o
);
   if (LAT < 1) begin : g_bad_lat
      $error("rs_exec_pipe: LAT must be at least 1");
   end

   logic [DATA_W-1:0] alu;
   always_comb begin
      unique case (in_op_i)
         OP_ADD:  alu = in_a_i + in_b_i;
         OP_SUB:  alu = in_a_i - in_b_i;
         OP_AND:  alu = in_a_i & in_b_i;
         default: alu = in_a_i ^ in_b_i;
      endcase
   end

   logic [LAT-1:0]             v_q;
   logic [LAT-1:0][TAG_W-1:0]  t_q;
   logic [LAT-1:0][DATA_W-1:0] d_q;

   for (genvar k = 0; k < LAT; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) v_q[k] <= 1'b0;
            else        v_q[k] <= in_valid_i;
            t_q[k] <= in_tag_i;
            d_q[k] <= alu;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) v_q[k] <= 1'b0;
            else        v_q[k] <= v_q[k-1];
            t_q[k] <= t_q[k-1];
            d_q[k] <= d_q[k-1];
         end
      end
   end

   assign out_valid_o = v_q[LAT-1];
   assign out_tag_o   = t_q[LAT-1];
   assign out_data_o  = d_q[LAT-1];

   AST_PIPE_TAG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> (out_tag_o != '0));  // R7
endmodule

// File: rtl/rs_cluster.sv
module rs_cluster
   import rs_pkg::*;
#(
   parameter int NUM_ST   = 4,
   parameter int DATA_W   = 16,
   parameter int TAG_W    = 3,
   parameter int BASE_TAG = 1,
   parameter int EXE_LAT  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              disp_valid,
   output logic              disp_ready,
   input  logic [1:0]        disp_op,
   input  logic [TAG_W-1:0]  disp_tag_a,
   input  logic [DATA_W-1:0] disp_val_a,
   input  logic [TAG_W-1:0]  disp_tag_b,
   input  logic [DATA_W-1:0] disp_val_b,
   input  logic              bus_in_valid,
   input  logic [TAG_W-1:0]  bus_in_tag,
   input  logic [DATA_W-1:0] bus_in_data,
   output logic              iss_valid,
   output logic [TAG_W-1:0]  iss_tag,
   output logic [1:0]        iss_op,
   output logic [DATA_W-1:0] iss_a,
   output logic [DATA_W-1:0] iss_b,
   output logic              res_valid,
   output logic [TAG_W-1:0]  res_tag,
   output logic [DATA_W-1:0] res_data
);
   localparam logic [TAG_W-1:0] TAG_LO = TAG_W'(BASE_TAG);
   localparam logic [TAG_W-1:0] TAG_HI = TAG_W'(BASE_TAG + NUM_ST - 1);

   if (BASE_TAG < 1) begin : g_bad_base
      $error("rs_cluster: tag zero is reserved for present values");
   end
   if (BASE_TAG + NUM_ST - 1 >= (1 << TAG_W)) begin : g_bad_tagw
      $error("rs_cluster: TAG_W too narrow for the station tags");
   end

   logic [NUM_ST-1:0] busy_vec, rdy_vec, alloc_gnt, alloc_vec, iss_gnt, free_vec;
   logic              iss_any;
   rs_op_e            st_op [NUM_ST];
   logic [NUM_ST-1:0][NUM_SRC-1:0][DATA_W-1:0] st_opnd;

   logic [NUM_BUS-1:0]              bv;
   logic [NUM_BUS-1:0][TAG_W-1:0]   bt;
   logic [NUM_BUS-1:0][DATA_W-1:0]  bd;
   logic [NUM_SRC-1:0][TAG_W-1:0]   d_tag;
   logic [NUM_SRC-1:0][DATA_W-1:0]  d_val;

   assign bv    = {res_valid, bus_in_valid};
   assign bt    = {res_tag,   bus_in_tag};
   assign bd    = {res_data,  bus_in_data};
   assign d_tag = {disp_tag_b, disp_tag_a};
   assign d_val = {disp_val_b, disp_val_a};

   rs_prio_pick #(.N(NUM_ST)) u_alloc_pick (
      .req_i (~busy_vec),
      .gnt_o (alloc_gnt),
      .any_o (disp_ready)
   );
   assign alloc_vec = alloc_gnt & {NUM_ST{disp_valid}};

   rs_prio_pick #(.N(NUM_ST)) u_issue_pick (
      .req_i (rdy_vec),
      .gnt_o (iss_gnt),
      .any_o (iss_any)
   );

   for (genvar i = 0; i < NUM_ST; i++) begin : g_st
      localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(BASE_TAG + i);
      assign free_vec[i] = res_valid && (res_tag == MY_TAG);

      rs_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_entry (
         .clk     (clk),
         .rst_n   (rst_n),
         .alloc_i (alloc_vec[i]),
         .op_i    (rs_op_e'(disp_op)),
         .tag_i   (d_tag),
         .val_i   (d_val),
         .bus_v_i (bv),
         .bus_t_i (bt),
         .bus_d_i (bd),
         .grant_i (iss_gnt[i]),
         .free_i  (free_vec[i]),
         .busy_o  (busy_vec[i]),
         .ready_o (rdy_vec[i]),
         .op_o    (st_op[i]),
         .opnd_o  (st_opnd[i])
      );
   end

   rs_op_e iss_op_e;
   always_comb begin
      iss_tag  = '0;
      iss_op_e = OP_ADD;
      iss_a    = '0;
      iss_b    = '0;
      for (int i = 0; i < NUM_ST; i++) begin
         if (iss_gnt[i]) begin
            iss_tag  = TAG_W'(BASE_TAG + i);
            iss_op_e = st_op[i];
            iss_a    = st_opnd[i][0];
            iss_b    = st_opnd[i][1];
         end
      end
   end
   assign iss_valid = iss_any;
   assign iss_op    = iss_op_e;

   rs_exec_pipe #(.DATA_W(DATA_W), .TAG_W(TAG_W), .LAT(EXE_LAT)) u_exec (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid_i  (iss_valid),
      .in_op_i     (iss_op_e),
      .in_a_i      (iss_a),
      .in_b_i      (iss_b),
      .in_tag_i    (iss_tag),
      .out_valid_o (res_valid),
      .out_tag_o   (res_tag),
      .out_data_o  (res_data)
   );

   AST_ISSUE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(iss_gnt));  // R5
   AST_ALLOC_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_vec & busy_vec) == '0);  // R8
   AST_RES_TAG_OWN: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_tag >= TAG_LO && res_tag <= TAG_HI));  // R7
   AST_FREE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(free_vec));  // R9
endmodule

// File: tb/tb_rs_cluster.sv
module tb_rs_cluster;
   localparam int DW = 8;
   localparam int TW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          disp_valid = 1'b0;
   logic          disp_ready;
   logic [1:0]    disp_op = '0;
   logic [TW-1:0] disp_tag_a = '0, disp_tag_b = '0;
   logic [DW-1:0] disp_val_a = '0, disp_val_b = '0;
   logic          bus_in_valid = 1'b0;
   logic [TW-1:0] bus_in_tag = '0;
   logic [DW-1:0] bus_in_data = '0;
   logic          iss_valid;
   logic [TW-1:0] iss_tag;
   logic [1:0]    iss_op;
   logic [DW-1:0] iss_a, iss_b;
   logic          res_valid;
   logic [TW-1:0] res_tag;
   logic [DW-1:0] res_data;

   rs_cluster #(.NUM_ST(4), .DATA_W(DW), .TAG_W(TW), .BASE_TAG(1), .EXE_LAT(2)) dut (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
      .disp_tag_a(disp_tag_a), .disp_val_a(disp_val_a),
      .disp_tag_b(disp_tag_b), .disp_val_b(disp_val_b),
      .bus_in_valid(bus_in_valid), .bus_in_tag(bus_in_tag), .bus_in_data(bus_in_data),
      .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_op(iss_op),
      .iss_a(iss_a), .iss_b(iss_b),
      .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data)
   );

   always #10 clk = ~clk;

   int n_chk = 0, n_bad = 0, evcnt = 0;
   bit mon_en = 1'b0;
   bit finished = 1'b0;
   logic [DW-1:0] exp_q [128];
   int wr_p = 0, rd_p = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic set_disp(input bit v, input int op, input int ta, input int va,
                           input int tb, input int vb);
      disp_valid = v;
      disp_op    = 2'(op);
      disp_tag_a = TW'(ta);
      disp_val_a = DW'(va);
      disp_tag_b = TW'(tb);
      disp_val_b = DW'(vb);
   endtask

   task automatic set_bus(input bit v, input int t, input int d);
      bus_in_valid = v;
      bus_in_tag   = TW'(t);
      bus_in_data  = DW'(d);
   endtask

   task automatic chk_iss(input string req, input int tag);
      chk(iss_valid && int'(iss_tag) == tag, req, iss_valid ? int'(iss_tag) : -1, tag);
   endtask

   task automatic chk_res(input string req, input int tag, input int data);
      chk(res_valid && int'(res_tag) == tag, req, res_valid ? int'(res_tag) : -1, tag);
      chk(int'(res_data) == data, req, int'(res_data), data);
   endtask

   function automatic logic [DW-1:0] model(input int op, input logic [DW-1:0] a,
                                           input logic [DW-1:0] b);
      case (op)
         0: return a + b;
         1: return a - b;
         2: return a & b;
         default: return a ^ b;
      endcase
   endfunction

   always @(negedge clk) begin
      if (res_valid) evcnt++;
      if (mon_en && res_valid) begin
         chk(res_data == exp_q[rd_p % 128], "R2 sweep result", int'(res_data),
             int'(exp_q[rd_p % 128]));
         rd_p++;
      end
   end

   initial begin
      #(20 * 100000);
      if (!finished) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] vals [5];
      int base;
      vals[0] = 8'h00; vals[1] = 8'h01; vals[2] = 8'h7f; vals[3] = 8'h80; vals[4] = 8'hff;

      repeat (3) tick();
      // R1: reset state
      chk(disp_ready == 1'b1, "R1 reset ready", int'(disp_ready), 1);
      chk(iss_valid == 1'b0, "R1 reset issue", int'(iss_valid), 0);
      chk(res_valid == 1'b0, "R1 reset result", int'(res_valid), 0);
      rst_n = 1'b1;
      repeat (2) tick();

      // R2: opcode sweep, all operands present, results in dispatch order
      mon_en = 1'b1;
      for (int op = 0; op < 4; op++)
         for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++) begin
               tick();
               while (!disp_ready) begin
                  set_disp(0, 0, 0, 0, 0, 0);
                  tick();
               end
               set_disp(1, op, 0, int'(vals[i]), 0, int'(vals[j]));
               exp_q[wr_p % 128] = model(op, vals[i], vals[j]);
               wr_p++;
            end
      tick();
      set_disp(0, 0, 0, 0, 0, 0);
      repeat (10) tick();
      mon_en = 1'b0;
      chk(rd_p == wr_p, "R2 sweep drained", rd_p, wr_p);

      // R3 R5 R6 R11: out-of-order issue and external wakeup
      set_disp(1, 0, 5, 0, 0, 3);                       // tag1: a waits on 5
      tick();
      set_disp(1, 1, 0, 10, 5, 0);                      // tag2: b waits on 5
      chk(!iss_valid, "R3 waiting station idle", int'(iss_valid), 0);
      tick();
      set_disp(1, 3, 0, 7, 0, 2);                       // tag3: ready
      chk(!iss_valid, "R3 waiting station idle", int'(iss_valid), 0);
      tick();
      set_disp(0, 0, 0, 0, 0, 0);
      set_bus(1, 6, 99);
      chk_iss("R6 younger ready station issues", 3);
      chk(int'(iss_a) == 7, "R6 operand a", int'(iss_a), 7);
      tick();
      set_bus(1, 5, 20);
      chk(!iss_valid, "R11 unmatched tag ignored", int'(iss_valid), 0);
      tick();
      set_bus(0, 0, 0);
      chk_iss("R5 lowest ready first", 1);
      chk(int'(iss_a) == 20, "R3 captured a", int'(iss_a), 20);
      chk_res("R7 result tag3", 3, 5);
      tick();
      chk_iss("R5 second ready", 2);
      chk(int'(iss_b) == 20, "R3 same-cycle capture b", int'(iss_b), 20);
      tick();
      chk_res("R2 add result", 1, 23);
      tick();
      chk_res("R2 sub wraps", 2, 246);
      repeat (6) tick();

      // R4 R10: chaining on own bus, bypass at dispatch
      set_disp(1, 0, 0, 1, 0, 2);                       // tag1 = 3
      tick();
      set_disp(1, 0, 1, 0, 0, 4);                       // tag2 = tag1 + 4
      chk_iss("R1 first free station", 1);
      tick();
      set_disp(0, 0, 0, 0, 0, 0);
      tick();
      set_disp(1, 1, 0, 5, 1, 0);                       // tag3 = 5 - tag1 (bus now)
      chk_res("R4 producer result", 1, 3);
      tick();
      set_disp(0, 0, 0, 0, 0, 0);
      chk_iss("R4 chained issue", 2);
      chk(int'(iss_a) == 3, "R4 own bus value", int'(iss_a), 3);
      tick();
      chk_iss("R10 bypass issue", 3);
      chk(int'(iss_b) == 3, "R10 bypass value", int'(iss_b), 3);
      tick();
      chk_res("R4 chained result", 2, 7);
      tick();
      chk_res("R10 bypass result", 3, 2);
      repeat (6) tick();

      // R8 R9: full cluster, refused dispatch, freeing time
      for (int k = 1; k <= 4; k++) begin
         set_disp(1, 0, 7, 0, 0, k);
         tick();
      end
      chk(!disp_ready, "R8 full stalls", int'(disp_ready), 0);
      set_disp(1, 0, 0, 50, 0, 50);
      base = evcnt;
      tick();
      chk(!disp_ready, "R8 full stalls", int'(disp_ready), 0);
      tick();
      set_disp(0, 0, 0, 0, 0, 0);
      set_bus(1, 7, 1);
      tick();
      set_bus(0, 0, 0);
      chk_iss("R5 wake all, lowest", 1);
      tick();
      chk_iss("R5 order", 2);
      tick();
      chk_iss("R5 order", 3);
      chk_res("R9 broadcast", 1, 2);
      chk(!disp_ready, "R9 busy during broadcast", int'(disp_ready), 0);
      tick();
      chk_iss("R5 order", 4);
      chk(disp_ready, "R9 free after broadcast", int'(disp_ready), 1);
      chk_res("R7 tag2", 2, 3);
      tick();
      chk(!iss_valid, "R8 no phantom issue", int'(iss_valid), 0);
      chk_res("R7 tag3", 3, 4);
      tick();
      chk_res("R7 tag4", 4, 5);
      repeat (6) tick();
      chk(evcnt - base == 4, "R8 refused dispatch left no result", evcnt - base, 4);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule